// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a 32-bit down-counting timer paced by a bus tick strobe. Software programs three things: a divide code that sets how many bus ticks make one counter step, an initial count that starts a countdown, and a timer entry holding the interrupt vector, a mask bit and a periodic-or-one-shot selection. A separate spurious-vector register carries a software-enable bit, and the timer entry is forced masked whenever that bit is clear.

When the count runs out, the block emits a one-cycle interrupt request together with the vector taken from the timer entry, unless the entry is masked. A periodic timer reloads the initial count and keeps going; a one-shot timer parks at zero. The current count is always visible, so software can read how far the countdown has progressed. Address decoding and interrupt arbitration sit outside the block: each register has its own write strobe and its own read-back port.

Top module: `local_irq_timer`

## Requirements
- R1: After reset the divide code, initial count and current count read 0, the timer entry reads 0x0001_0000 (masked), the spurious-vector register reads 0x0000_00FF (software-disabled) and no request is raised.
- R2: A divide-code write keeps only data bits 3, 1 and 0; every other bit of the divide-code read-back is 0.
- R3: The divisor is 2 raised to (({bit3,bit1,bit0} + 1) mod 8): code 0x0 divides by 2, 0x3 by 16, 0x8 by 32, 0xA by 128 and 0xB by 1; with the bus tick present every cycle, the request comes initial count × divisor cycles after the cycle of the load write.
- R4: The count changes only on divided ticks: the current count equals the initial count minus the divided ticks since the last load or reload, and it holds while the bus tick is absent.
- R5: An initial-count write starts a fresh countdown from the new value at any time, discarding the prescaler progress, and the current count shows the new value in the next cycle.
- R6: With entry bit 17 clear (one-shot) the timer requests once, the current count rests at 0, and no further request follows.
- R7: With entry bit 17 set (periodic) the current count reloads to the initial count on expiry and requests repeat every initial count × divisor cycles.
- R8: With entry bit 16 set (masked) an expiry raises no request, yet a periodic timer still reloads.
- R9: The request is high for exactly one cycle, in the same cycle the current count first shows 0 or the reloaded value, and carries entry bits 7:0 as its vector.
- R10: A timer-entry write keeps only bits 17, 16, 12 and 7:0 of the data; all other bits read 0.
- R11: While spurious-vector bit 8 is clear, every timer-entry write stores bit 16 set regardless of the data.
- R12: A spurious-vector write keeps data bits 9:0; writing it with bit 8 clear sets bit 16 of the timer entry in the same cycle, and setting bit 8 again leaves the entry unchanged.
- R13: An initial count of 0 leaves the timer idle: the current count stays 0 and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_tick | input | 1 | One-cycle strobe marking a bus cycle |
| div_wr | input | 1 | Write strobe for the divide code |
| init_wr | input | 1 | Write strobe for the initial count |
| entry_wr | input | 1 | Write strobe for the timer entry |
| spur_wr | input | 1 | Write strobe for the spurious-vector register |
| wr_data | input | 32 | Write data shared by all strobes |
| div_rd | output | 32 | Divide code read-back |
| init_rd | output | 32 | Initial count read-back |
| count_rd | output | 32 | Current count |
| entry_rd | output | 32 | Timer entry read-back |
| spur_rd | output | 32 | Spurious-vector register read-back |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_vec | output | 8 | Vector accompanying the request |

## Verification
Every register write is captured on the edge that ends its strobe cycle, so all read-back values, including the forced mask from a software disable, are due one cycle after the strobe and are sampled on the following falling edge. The expiry latency is counted in rising edges from the load edge and must equal initial count × divisor exactly; the request and the zero or reloaded count are due in that same cycle, and the cycle after is checked for the request having dropped. Mid-count values are predicted by counting divided ticks edge by edge, including stretches with the bus tick held low.

// File: rtl/lit_pkg.sv
package lit_pkg;
  localparam int REG_W   = 32;
  localparam int CODE_W  = 3;
  localparam int PRE_W   = (1 << CODE_W) - 1;

  localparam logic [REG_W-1:0] DIV_KEEP   = 32'h0000_000B;
  localparam logic [REG_W-1:0] ENTRY_KEEP = 32'h0003_10FF;
  localparam logic [REG_W-1:0] SPUR_KEEP  = 32'h0000_03FF;
  localparam logic [REG_W-1:0] ENTRY_RST  = 32'h0001_0000;
  localparam logic [REG_W-1:0] SPUR_RST   = 32'h0000_00FF;

  localparam int MASK_BIT   = 16;
  localparam int PERIOD_BIT = 17;
  localparam int SWEN_BIT   = 8;

  typedef logic [CODE_W-1:0] shift_t;

  function automatic shift_t code_to_shift(input logic [3:0] code);
    shift_t packed_code;
    packed_code = {code[3], code[1:0]};
    return shift_t'(packed_code + shift_t'(1));
  endfunction
endpackage

// File: rtl/lit_rst_sync.sv
module lit_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/lit_div_decode.sv
module lit_div_decode
  import lit_pkg::*;
(
  input  logic [3:0]       code,
  output logic [PRE_W-1:0] div_last
);
  shift_t           shift;
  logic [PRE_W:0]   pow;

  always_comb begin
    shift    = code_to_shift(code);
    pow      = (PRE_W+1)'(1) << shift;
    div_last = PRE_W'(pow - (PRE_W+1)'(1));
  end
endmodule

// File: rtl/lit_prescaler.sv
module lit_prescaler
  import lit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_tick,
  input  logic             restart,
  input  logic [PRE_W-1:0] div_last,
  output logic             div_tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic             pre_en;

  always_comb begin
    div_tick = bus_tick && (pre_q >= div_last);
    pre_en   = restart || bus_tick;
    if (restart)       pre_d = '0;
    else if (div_tick) pre_d = '0;
    else               pre_d = pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end
endmodule

// File: rtl/lit_down_counter.sv
module lit_down_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             div_tick,
  input  logic             periodic,
  output logic             expire,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload_val
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] init_q;
  logic             run_q, run_d;
  logic             step;

  always_comb begin
    step   = run_q && div_tick && !load;
    expire = step && (cnt_q == CNT_W'(1));
    cnt_d  = cnt_q;
    run_d  = run_q;
    if (load) begin
      cnt_d = load_val;
      run_d = (load_val != '0);
    end else if (expire) begin
      if (periodic) begin
        cnt_d = init_q;
      end else begin
        cnt_d = '0;
        run_d = 1'b0;
      end
    end else if (step) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load || step) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    init_q <= '0;
    else if (load) init_q <= load_val;
  end

  assign count      = cnt_q;
  assign reload_val = init_q;
endmodule

// File: rtl/lit_cfg_regs.sv
module lit_cfg_regs
  import lit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic             entry_wr,
  input  logic             spur_wr,
  input  logic [REG_W-1:0] wr_data,
  output logic [3:0]       div_code,
  output logic [REG_W-1:0] entry,
  output logic [REG_W-1:0] spur
);
  logic [3:0]       code_q, code_d;
  logic [REG_W-1:0] entry_q, entry_d;
  logic [REG_W-1:0] spur_q, spur_d;
  logic             sw_off_now;
  logic             sw_off_wr;
  logic             entry_en;

  always_comb begin
    code_d     = 4'(wr_data & DIV_KEEP);
    spur_d     = wr_data & SPUR_KEEP;
    sw_off_now = !spur_q[SWEN_BIT];
    sw_off_wr  = spur_wr && !wr_data[SWEN_BIT];
    entry_en   = entry_wr || sw_off_wr;
    entry_d    = entry_wr ? (wr_data & ENTRY_KEEP) : entry_q;
    if ((entry_wr && sw_off_now) || sw_off_wr)
      entry_d[MASK_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= '0;
    else if (div_wr) code_q <= code_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        entry_q <= ENTRY_RST;
    else if (entry_en) entry_q <= entry_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       spur_q <= SPUR_RST;
    else if (spur_wr) spur_q <= spur_d;
  end

  assign div_code = code_q;
  assign entry    = entry_q;
  assign spur     = spur_q;
endmodule

// File: rtl/local_irq_timer.sv
module local_irq_timer
  import lit_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_tick,
  input  logic             div_wr,
  input  logic             init_wr,
  input  logic             entry_wr,
  input  logic             spur_wr,
  input  logic [31:0]      wr_data,
  output logic [31:0]      div_rd,
  output logic [CNT_W-1:0] init_rd,
  output logic [CNT_W-1:0] count_rd,
  output logic [31:0]      entry_rd,
  output logic [31:0]      spur_rd,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);
  logic             rst_sync_n;
  logic [3:0]       div_code;
  logic [PRE_W-1:0] div_last;
  logic             div_tick;
  logic             expire;
  logic             irq_q, irq_d;
  logic [VEC_W-1:0] vec_q;

  lit_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lit_cfg_regs u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .div_wr   (div_wr),
    .entry_wr (entry_wr),
    .spur_wr  (spur_wr),
    .wr_data  (wr_data),
    .div_code (div_code),
    .entry    (entry_rd),
    .spur     (spur_rd)
  );

  lit_div_decode u_dec (
    .code     (div_code),
    .div_last (div_last)
  );

  lit_prescaler u_pre (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bus_tick (bus_tick),
    .restart  (init_wr),
    .div_last (div_last),
    .div_tick (div_tick)
  );

  lit_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (init_wr),
    .load_val   (wr_data[CNT_W-1:0]),
    .div_tick   (div_tick),
    .periodic   (entry_rd[PERIOD_BIT]),
    .expire     (expire),
    .count      (count_rd),
    .reload_val (init_rd)
  );

  always_comb begin
    irq_d = expire && !entry_rd[MASK_BIT];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) vec_q <= '0;
    else if (expire) vec_q <= entry_rd[VEC_W-1:0];
  end

  assign div_rd  = {28'b0, div_code};
  assign irq_req = irq_q;
  assign irq_vec = vec_q;
endmodule

// File: rtl/local_irq_timer_chk.sv
module local_irq_timer_chk #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             div_wr,
  input logic             init_wr,
  input logic [31:0]      wr_data,
  input logic [31:0]      div_rd,
  input logic [CNT_W-1:0] init_rd,
  input logic [CNT_W-1:0] count_rd,
  input logic [31:0]      entry_rd,
  input logic [31:0]      spur_rd,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec
);
  assert_div_filter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> div_rd == {28'b0, $past(wr_data[3]), 1'b0, $past(wr_data[1:0])});

  assert_load_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    init_wr |=> (count_rd == $past(wr_data[CNT_W-1:0])) && (init_rd == count_rd));

  assert_oneshot_rest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !$past(entry_rd[17])) |-> count_rd == '0);

  assert_periodic_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && $past(entry_rd[17])) |-> count_rd == init_rd);

  assert_mask_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !$past(entry_rd[16]));

  assert_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_vec == $past(entry_rd[VEC_W-1:0]));

  assert_swoff_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !spur_rd[8] |-> entry_rd[16]);

  assert_zero_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (init_rd == '0) |-> !irq_req);
endmodule

bind local_irq_timer local_irq_timer_chk #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .div_wr   (div_wr),
  .init_wr  (init_wr),
  .wr_data  (wr_data),
  .div_rd   (div_rd),
  .init_rd  (init_rd),
  .count_rd (count_rd),
  .entry_rd (entry_rd),
  .spur_rd  (spur_rd),
  .irq_req  (irq_req),
  .irq_vec  (irq_vec)
);

// File: tb/local_irq_timer_test.sv
module local_irq_timer_test;
  logic        clk;
  logic        rst_n;
  logic        bus_tick;
  logic        div_wr, init_wr, entry_wr, spur_wr;
  logic [31:0] wr_data;
  logic [31:0] div_rd, init_rd, count_rd, entry_rd, spur_rd;
  logic        irq_req;
  logic [7:0]  irq_vec;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  local_irq_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick),
    .div_wr(div_wr), .init_wr(init_wr), .entry_wr(entry_wr), .spur_wr(spur_wr),
    .wr_data(wr_data), .div_rd(div_rd), .init_rd(init_rd), .count_rd(count_rd),
    .entry_rd(entry_rd), .spur_rd(spur_rd), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // sel: 0 divide code, 1 initial count, 2 timer entry, 3 spurious vector
  task automatic wr(input int sel, input logic [31:0] data);
    @(negedge clk);
    wr_data  = data;
    div_wr   = (sel == 0);
    init_wr  = (sel == 1);
    entry_wr = (sel == 2);
    spur_wr  = (sel == 3);
    @(negedge clk);
    div_wr = 0; init_wr = 0; entry_wr = 0; spur_wr = 0;
  endtask

  // counts rising edges after the load edge until the request is seen
  task automatic wait_irq(output int cycles);
    cycles = 0;
    for (int k = 1; k <= 600; k++) begin
      @(negedge clk);
      if (irq_req) begin
        cycles = k;
        break;
      end
    end
  endtask

  task automatic t_reset;
    chk("R1 div", div_rd, 32'h0);
    chk("R1 init", init_rd, 32'h0);
    chk("R1 count", count_rd, 32'h0);
    chk("R1 entry", entry_rd, 32'h0001_0000);
    chk("R1 spur", spur_rd, 32'h0000_00FF);
    chk("R1 irq", {31'b0, irq_req}, 32'h0);
  endtask

  task automatic t_div_filter;
    wr(0, 32'hFFFF_FFF4);
    chk("R2 drop", div_rd, 32'h0);
    wr(0, 32'hFFFF_FFFF);
    chk("R2 keep", div_rd, 32'h0000_000B);
  endtask

  task automatic t_div_timing(input logic [31:0] code, input int divisor);
    int cyc;
    wr(3, 32'h1FF);
    wr(2, 32'h0000_0040);
    wr(0, code);
    wr(1, 32'd3);
    wait_irq(cyc);
    chk($sformatf("R3 code 0x%0h", code), cyc, 3 * divisor);
    chk("R9 vector", {24'b0, irq_vec}, 32'h40);
    chk("R9 count with pulse", count_rd, 32'h0);
    @(negedge clk);
    chk("R9 pulse width", {31'b0, irq_req}, 32'h0);
  endtask

  task automatic t_oneshot_quiet;
    int seen = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (irq_req) seen++;
    end
    chk("R6 no refire", seen, 0);
    chk("R6 rests at zero", count_rd, 32'h0);
  endtask

  task automatic t_current_count;
    int cyc;
    wr(2, 32'h0000_0041);
    wr(0, 32'h0);
    wr(1, 32'd10);
    chk("R5 load visible", count_rd, 32'd10);
    repeat (6) @(negedge clk);
    chk("R4 after three divided ticks", count_rd, 32'd7);
    bus_tick = 0;
    repeat (20) @(negedge clk);
    chk("R4 hold without bus tick", count_rd, 32'd7);
    bus_tick = 1;
    wr(1, 32'd5);
    chk("R5 reload value", count_rd, 32'd5);
    wait_irq(cyc);
    chk("R5 fresh countdown", cyc, 10);
  endtask

  task automatic t_periodic;
    int cyc;
    wr(2, 32'h0002_0055);
    wr(0, 32'hB);
    wr(1, 32'd4);
    wait_irq(cyc);
    chk("R7 first period", cyc, 4);
    chk("R7 reloaded", count_rd, 32'd4);
    chk("R9 vector periodic", {24'b0, irq_vec}, 32'h55);
    wait_irq(cyc);
    chk("R7 second period", cyc, 4);
  endtask

  task automatic t_masked;
    int seen = 0;
    logic [31:0] at8;
    wr(2, 32'h0003_0066);
    wr(1, 32'd4);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (irq_req) seen++;
      if (k == 8) at8 = count_rd;
      if (k == 5) chk("R8 counting after reload", count_rd, 32'd3);
    end
    chk("R8 no request", seen, 0);
    chk("R8 reloaded at k=8", at8, 32'd4);
  endtask

  task automatic t_zero;
    int seen = 0;
    wr(2, 32'h0002_0077);
    wr(1, 32'd0);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (irq_req) seen++;
    end
    chk("R13 no request", seen, 0);
    chk("R13 count idle", count_rd, 32'h0);
  endtask

  task automatic t_entry_filter;
    wr(2, 32'hFFFF_FFFF);
    chk("R10 keep bits", entry_rd, 32'h0003_10FF);
    wr(2, 32'hFFFE_EF00);
    chk("R10 drop bits", entry_rd, 32'h0002_0000);
  endtask

  task automatic t_sw_disable;
    wr(3, 32'h0000_00FF);
    chk("R12 disable masks entry", entry_rd, 32'h0003_0000);
    chk("R12 spur value", spur_rd, 32'h0000_00FF);
    wr(2, 32'h0000_00AA);
    chk("R11 forced mask", entry_rd, 32'h0001_00AA);
    wr(3, 32'hFFFF_FFFF);
    chk("R12 spur keep bits", spur_rd, 32'h0000_03FF);
    chk("R12 enable leaves entry", entry_rd, 32'h0001_00AA);
    wr(2, 32'h0000_00AA);
    chk("R11 unmasked when enabled", entry_rd, 32'h0000_00AA);
  endtask

  initial begin
    rst_n = 0; bus_tick = 1;
    div_wr = 0; init_wr = 0; entry_wr = 0; spur_wr = 0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_div_filter();
    t_div_timing(32'h0, 2);
    t_oneshot_quiet();
    t_div_timing(32'hB, 1);
    t_div_timing(32'hA, 128);
    t_div_timing(32'h3, 16);
    t_div_timing(32'h8, 32);
    t_current_count();
    t_periodic();
    t_masked();
    t_zero();
    t_entry_filter();
    t_sw_disable();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule